// File: doc/BRIEF.md
# ADC Control and Status Register Front End

This block is the register-side front end of an on-chip analog-to-digital converter in an 8-bit microcontroller. Software reaches it through a byte-wide special-function-register port made of an address, a write strobe, write data and combinational read data. Two registers sit on that port. One is a control/status register. The other is a clock-divider register that sets the rate of the converter's clock.

Towards the converter, the block drives a power enable, a channel select, a one-cycle start pulse and a clock-enable strobe derived from the system clock. It accepts a one-cycle done pulse in return. Towards the processor, it raises an end-of-conversion interrupt request and a suspend request that holds the core quiet while a conversion runs. The analog converter and its result registers are outside the block.

Top module: `adc_sfr_front`

## Requirements
- R1: After reset, both registers read 00h, and convStart, convClkEn, convEnable, cpuSuspend and eocIrq are all low.
- R2: The control register sits at address F3h with this layout: bit 6 = pseudo-idle, bit 5 = enable, bit 4 = end-of-conversion flag, bit 3 = busy/start, bit 0 = channel select. The divider register sits at F2h with its value in bits 4..0. Any other address reads 00h.
- R3: Bit 7 and bits 2..1 of the control register, and bits 7..5 of the divider register, always read 0, whatever was written to them.
- R4: A write to F3h with bit 3 = 1 and bit 5 = 1, made while no conversion is running, sets bit 3 and drives convStart high for exactly the next cycle. A start written with bit 5 = 0 is ignored. A start written while bit 3 already reads 1 gives no new pulse. Writing 0 to bit 3 never clears it.
- R5: A convDone pulse while bit 3 is set clears bit 3 and sets bit 4 on the same clock edge. A convDone pulse while bit 3 is clear changes nothing.
- R6: Writing 0 to bit 4 clears the end-of-conversion flag, and writing 1 to bit 4 leaves it unchanged. When convDone finishes a conversion in the same cycle that software writes bit 4 to 0, the flag ends up set.
- R7: eocIrq is high exactly when bit 4 is set and the intEnable input is high.
- R8: cpuSuspend is high while both bit 6 and bit 3 are set. The end of a conversion clears bit 6.
- R9: convEnable follows bit 5. convChannel is 0 when bit 0 = 1 and 1 when bit 0 = 0.
- R10: While bit 5 is set, convClkEn pulses once every (divider value + 1) system clocks, so a divider of 0 gives one pulse on every clock. While bit 5 is clear, convClkEn stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sfrAddr | input | 8 | Register address |
| sfrWe | input | 1 | Write strobe |
| sfrWdata | input | 8 | Write data |
| sfrRdata | output | 8 | Read data (combinational on sfrAddr) |
| intEnable | input | 1 | External interrupt enable for the end-of-conversion flag |
| convDone | input | 1 | One-cycle pulse from the converter: result ready |
| convStart | output | 1 | One-cycle pulse that starts a conversion |
| convChannel | output | 1 | Channel number given to the converter |
| convEnable | output | 1 | Converter power enable (low = standby) |
| convClkEn | output | 1 | Converter clock-enable strobe |
| eocIrq | output | 1 | End-of-conversion interrupt request |
| cpuSuspend | output | 1 | Core suspend request during a conversion |

## Verification
Two actions can fall on the same clock edge: the converter's done pulse, which sets the end-of-conversion flag, and a software write that clears that flag. The bench starts a conversion, then raises convDone in the very cycle that carries a write of 0 to bit 4 of F3h. It passes if the read-back afterwards shows the flag set and the busy bit clear. A second case covers a start written while a conversion is already running: the bench confirms that no second start pulse appears.

// File: rtl/adc_sfr_pkg.sv
package adc_sfr_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 5;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'hF3;
  localparam logic [ADDR_W-1:0] DIV_ADDR  = 8'hF2;

  // control register bit positions (software-visible layout)
  localparam int BIT_IDLE = 6;
  localparam int BIT_EN   = 5;
  localparam int BIT_EOC  = 4;
  localparam int BIT_BUSY = 3;
  localparam int BIT_CHAN = 0;

  typedef struct packed {
    logic wrCtrl;  // write to control register
    logic wrDiv;   // write to divider register
    logic launch;  // accepted start request
    logic finish;  // conversion completed
  } adcStrobe_t;
endpackage

// File: rtl/adc_sfr_ctrl.sv
module adc_sfr_ctrl
  import adc_sfr_pkg::*;
(
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic              sfrWe,
  input  logic              startBit,
  input  logic              enBit,
  input  logic              convDone,
  input  logic              busy,
  output adcStrobe_t        strobe
);
  logic hitCtrl;
  logic hitDiv;

  always_comb begin
    hitCtrl = sfrWe && (sfrAddr == CTRL_ADDR);
    hitDiv  = sfrWe && (sfrAddr == DIV_ADDR);
    strobe.wrCtrl = hitCtrl;
    strobe.wrDiv  = hitDiv;
    // start accepted only with enable in the same write and no conversion active
    strobe.launch = hitCtrl && startBit && enBit && !busy;
    // done only counts while a conversion is in flight
    strobe.finish = convDone && busy;
  end
endmodule

// File: rtl/adc_sfr_datapath.sv
module adc_sfr_datapath
  import adc_sfr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  adcStrobe_t        strobe,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic              wrIdle,
  input  logic              wrEn,
  input  logic              wrEoc,
  input  logic              wrChan,
  input  logic [DIV_W-1:0]  wrDivVal,
  output logic [DATA_W-1:0] sfrRdata,
  output logic              busy,
  output logic              eoc,
  output logic              idle,
  output logic              en,
  output logic              chan,
  output logic              convStart,
  output logic              convClkEn
);
  logic [DIV_W-1:0] divQ;
  logic [DIV_W-1:0] cntQ;
  logic             wrap;

  // control / status register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idle      <= 1'b0;
      en        <= 1'b0;
      eoc       <= 1'b0;
      busy      <= 1'b0;
      chan      <= 1'b0;
      convStart <= 1'b0;
    end else begin
      if (strobe.wrCtrl) begin
        idle <= wrIdle;
        en   <= wrEn;
        chan <= wrChan;
        if (!wrEoc) eoc <= 1'b0;
      end
      if (strobe.launch) busy <= 1'b1;
      // hardware completion takes priority over a same-cycle software write
      if (strobe.finish) begin
        busy <= 1'b0;
        idle <= 1'b0;
        eoc  <= 1'b1;
      end
      convStart <= strobe.launch;
    end
  end

  // divider register
  always_ff @(posedge clk) begin
    if (!rstN) divQ <= '0;
    else if (strobe.wrDiv) divQ <= wrDivVal;
  end

  // converter clock-enable generator
  assign wrap      = (cntQ >= divQ);
  assign convClkEn = en && wrap;

  always_ff @(posedge clk) begin
    if (!rstN || !en) cntQ <= '0;
    else if (wrap)    cntQ <= '0;
    else              cntQ <= cntQ + 1'b1;
  end

  // read mux
  always_comb begin
    sfrRdata = '0;
    if (sfrAddr == CTRL_ADDR) begin
      sfrRdata[BIT_IDLE] = idle;
      sfrRdata[BIT_EN]   = en;
      sfrRdata[BIT_EOC]  = eoc;
      sfrRdata[BIT_BUSY] = busy;
      sfrRdata[BIT_CHAN] = chan;
    end else if (sfrAddr == DIV_ADDR) begin
      sfrRdata[DIV_W-1:0] = divQ;
    end
  end
endmodule

// File: rtl/adc_sfr_front.sv
module adc_sfr_front
  import adc_sfr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic              sfrWe,
  input  logic [DATA_W-1:0] sfrWdata,
  output logic [DATA_W-1:0] sfrRdata,
  input  logic              intEnable,
  input  logic              convDone,
  output logic              convStart,
  output logic              convChannel,
  output logic              convEnable,
  output logic              convClkEn,
  output logic              eocIrq,
  output logic              cpuSuspend
);
  adcStrobe_t strobe;
  logic busy;
  logic eoc;
  logic idle;
  logic en;
  logic chan;
  logic wdataUnused;

  assign wdataUnused = ^{sfrWdata[7], sfrWdata[2:1]};

  adc_sfr_ctrl u_ctrl (
    .sfrAddr  (sfrAddr),
    .sfrWe    (sfrWe),
    .startBit (sfrWdata[BIT_BUSY]),
    .enBit    (sfrWdata[BIT_EN]),
    .convDone (convDone),
    .busy     (busy),
    .strobe   (strobe)
  );

  adc_sfr_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .sfrAddr   (sfrAddr),
    .wrIdle    (sfrWdata[BIT_IDLE]),
    .wrEn      (sfrWdata[BIT_EN]),
    .wrEoc     (sfrWdata[BIT_EOC]),
    .wrChan    (sfrWdata[BIT_CHAN]),
    .wrDivVal  (sfrWdata[DIV_W-1:0]),
    .sfrRdata  (sfrRdata),
    .busy      (busy),
    .eoc       (eoc),
    .idle      (idle),
    .en        (en),
    .chan      (chan),
    .convStart (convStart),
    .convClkEn (convClkEn)
  );

  assign convEnable  = en;
  assign convChannel = ~chan;
  assign cpuSuspend  = idle && busy;
  assign eocIrq      = eoc && intEnable;
endmodule

// File: rtl/adc_sfr_front_chk.sv
module adc_sfr_front_chk
  import adc_sfr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] sfrAddr,
  input logic [DATA_W-1:0] sfrRdata,
  input logic              intEnable,
  input logic              convDone,
  input logic              convStart,
  input logic              convEnable,
  input logic              convClkEn,
  input logic              eocIrq,
  input logic              cpuSuspend,
  input logic              busy,
  input logic              eoc
);
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart); // R4
  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> (convEnable && busy)); // R4
  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && busy) |=> (eoc && !busy)); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (eoc && busy && convDone) |=> eoc); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    eocIrq |-> (intEnable && eoc)); // R7
  AST_SUSPEND_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    cpuSuspend |-> busy); // R8
  AST_NO_CLK_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !convEnable |-> !convClkEn); // R10
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (sfrAddr == CTRL_ADDR) |-> (sfrRdata[7] == 1'b0 && sfrRdata[2:1] == 2'b00)); // R3
endmodule

bind adc_sfr_front adc_sfr_front_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sfrAddr    (sfrAddr),
  .sfrRdata   (sfrRdata),
  .intEnable  (intEnable),
  .convDone   (convDone),
  .convStart  (convStart),
  .convEnable (convEnable),
  .convClkEn  (convClkEn),
  .eocIrq     (eocIrq),
  .cpuSuspend (cpuSuspend),
  .busy       (busy),
  .eoc        (eoc)
);

// File: tb/test_adc_sfr_front.sv
`timescale 1ns/1ps
module test_adc_sfr_front;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] sfrAddr = 8'h00;
  logic       sfrWe = 1'b0;
  logic [7:0] sfrWdata = 8'h00;
  logic [7:0] sfrRdata;
  logic       intEnable = 1'b0;
  logic       convDone = 1'b0;
  logic       convStart, convChannel, convEnable, convClkEn, eocIrq, cpuSuspend;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  adc_sfr_front i_adc_sfr_front (
    .clk(clk), .rstN(rstN), .sfrAddr(sfrAddr), .sfrWe(sfrWe),
    .sfrWdata(sfrWdata), .sfrRdata(sfrRdata), .intEnable(intEnable),
    .convDone(convDone), .convStart(convStart), .convChannel(convChannel),
    .convEnable(convEnable), .convClkEn(convClkEn), .eocIrq(eocIrq),
    .cpuSuspend(cpuSuspend)
  );

  task automatic check(input string tag, input int actual, input int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  task automatic sfrWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfrAddr = a; sfrWdata = d; sfrWe = 1'b1;
    @(negedge clk);
    sfrWe = 1'b0;
  endtask

  task automatic sfrRead(input logic [7:0] a, output logic [7:0] d);
    sfrAddr = a;
    #0.5;
    d = sfrRdata;
  endtask

  task automatic pulseDone();
    @(negedge clk);
    convDone = 1'b1;
    @(negedge clk);
    convDone = 1'b0;
  endtask

  task automatic testReset();
    logic [7:0] d;
    sfrRead(8'hF3, d); check("R1 ctrl reset", d, 8'h00);
    sfrRead(8'hF2, d); check("R1 div reset", d, 8'h00);
    check("R1 outputs low", {convStart, convClkEn, convEnable, cpuSuspend, eocIrq}, 0);
  endtask

  task automatic testRegs();
    logic [7:0] d;
    sfrWrite(8'hF3, 8'h08);  // start with enable clear: ignored
    check("R4 start w/o enable pulse", convStart, 0);
    sfrRead(8'hF3, d); check("R4 start w/o enable ignored", d, 8'h00);
    sfrWrite(8'hF3, 8'hA7);  // reserved bits plus enable and chan
    sfrRead(8'hF3, d); check("R3 ctrl reserved read 0", d, 8'h21);
    check("R9 enable follows bit5", convEnable, 1);
    check("R9 chan bit1 -> channel 0", convChannel, 0);
    sfrWrite(8'hF3, 8'h20);
    check("R9 chan bit0 -> channel 1", convChannel, 1);
    sfrWrite(8'hF2, 8'hFF);
    sfrRead(8'hF2, d); check("R3 div reserved read 0", d, 8'h1F);
    sfrRead(8'h10, d); check("R2 other address reads 0", d, 8'h00);
  endtask

  task automatic testStart();
    logic [7:0] d;
    sfrWrite(8'hF3, 8'h28);
    check("R4 start pulse", convStart, 1);
    sfrRead(8'hF3, d); check("R4 busy set", d, 8'h28);
    @(negedge clk);
    check("R4 pulse one cycle", convStart, 0);
    sfrWrite(8'hF3, 8'h28);
    check("R4 no restart while busy", convStart, 0);
    sfrWrite(8'hF3, 8'h20);
    sfrRead(8'hF3, d); check("R4 write 0 does not abort", d, 8'h28);
    pulseDone();
    sfrRead(8'hF3, d); check("R5 done clears busy sets flag", d, 8'h30);
  endtask

  task automatic testFlag();
    logic [7:0] d;
    intEnable = 1'b0; #0.5;
    check("R7 irq masked", eocIrq, 0);
    intEnable = 1'b1; #0.5;
    check("R7 irq raised", eocIrq, 1);
    sfrWrite(8'hF3, 8'h30);
    sfrRead(8'hF3, d); check("R6 write 1 keeps flag", d, 8'h30);
    sfrWrite(8'hF3, 8'h20);
    sfrRead(8'hF3, d); check("R6 write 0 clears flag", d, 8'h20);
    check("R7 irq low after clear", eocIrq, 0);
    pulseDone();
    sfrRead(8'hF3, d); check("R5 done while idle ignored", d, 8'h20);
    intEnable = 1'b0;
  endtask

  task automatic testSuspend();
    logic [7:0] d;
    sfrWrite(8'hF3, 8'h69);
    check("R8 suspend during conversion", cpuSuspend, 1);
    check("R9 channel 0 sent", convChannel, 0);
    pulseDone();
    check("R8 suspend released", cpuSuspend, 0);
    sfrRead(8'hF3, d); check("R8 idle bit cleared at end", d, 8'h31);
  endtask

  task automatic testCollide();
    logic [7:0] d;
    sfrWrite(8'hF3, 8'h20);
    sfrWrite(8'hF3, 8'h28);
    @(negedge clk);
    sfrAddr = 8'hF3; sfrWdata = 8'h20; sfrWe = 1'b1; convDone = 1'b1;
    @(negedge clk);
    sfrWe = 1'b0; convDone = 1'b0;
    sfrRead(8'hF3, d); check("R6 hardware set wins collision", d, 8'h30);
  endtask

  task automatic countClk(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      if (convClkEn) n++;
      @(negedge clk);
    end
  endtask

  task automatic testClk();
    int n;
    sfrWrite(8'hF2, 8'h02);
    countClk(30, n); check("R10 divider 2 -> every 3", n, 10);
    sfrWrite(8'hF2, 8'h00);
    countClk(20, n); check("R10 divider 0 -> every clock", n, 20);
    sfrWrite(8'hF2, 8'h04);
    countClk(25, n); check("R10 divider 4 -> every 5", n, 5);
    sfrWrite(8'hF3, 8'h00);
    countClk(20, n); check("R10 disabled no strobe", n, 0);
    check("R9 enable low", convEnable, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegs();
    testStart();
    testFlag();
    testSuspend();
    testCollide();
    testClk();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule